// File: doc/BRIEF.md
# Area Sensor Readout Sequencer

This block orders the readout of a frame from an area image sensor that has a parallel register feeding a serial register. It handles the row and pixel level sequence only. Separate phase generators create the gate waveforms, and this block drives them with one-cycle step requests. Each generator answers a request with a done strobe.

For every row, the sequencer asks for one parallel shift into the serial register. It then asks for one serial shift per column. After each serial step it emits a pixel strobe tagged with row and column, so that downstream logic can label each sample. This repeats until every row has been read.

Two modes are supported. In full-frame mode the light-sensitive array is also the readout path, so the shutter enable is held low for the whole readout. In frame-transfer mode the image array is first dumped row by row into an equal-sized storage array, with no serial activity during the dump. The storage array is then read out while the shutter stays open and the next exposure integrates.

Top module: `area_readout_seq`

## Requirements
- R1: After reset the block is idle. `readout_o` is 0, `shutter_en_o` is 1, and no shift request, `pixel_valid_o` or `frame_done_o` is asserted.
- R2: A `start_i` pulse seen while idle, with `rows_i` and `cols_i` both nonzero, begins a frame. `readout_o` reads 1 from the next cycle. A start with either count equal to zero is ignored and the block stays idle.
- R3: Every shift request is high for exactly one cycle and only while `readout_o` is 1. No further request is issued until the generator addressed by the last request has returned its done strobe.
- R4: In readout, each row gets exactly one parallel request followed by exactly `cols_i` serial requests before the next parallel request. A frame has `rows_i` parallel readout requests in total, and serial and parallel requests are never high together.
- R5: `pixel_valid_o` is high for one cycle, exactly one cycle after each cycle in which `ser_done_i` completes a serial step. `pix_row_o` and `pix_col_o` carry zero-based indices in row-major order.
- R6: `frame_done_o` pulses for one cycle, one cycle after the final `pixel_valid_o` of the frame. `readout_o` is already 0 in that cycle, and the frame has produced exactly rows times cols pixel strobes.
- R7: Full-frame mode (`ft_mode_i` = 0): parallel readout requests use `img_shift_o` alone. `shutter_en_o` is 0 for the whole time `readout_o` is 1, and returns to 1 when idle.
- R8: Frame-transfer mode (`ft_mode_i` = 1): the frame begins with `rows_i` dump requests, each asserting `img_shift_o` and `stor_shift_o` together, with no serial request until the dump completes. The readout parallel requests then use `stor_shift_o` alone. `shutter_en_o` stays 1 throughout.
- R9: While a frame is in progress, `start_i` and any change to `ft_mode_i`, `rows_i` or `cols_i` have no effect. The frame completes as started, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request |
| ft_mode_i | input | 1 | 1 = frame-transfer, 0 = full-frame; captured at start |
| rows_i | input | CNT_W | Rows per frame, 1 to MAX_DIM |
| cols_i | input | CNT_W | Columns per row, 1 to MAX_DIM |
| par_done_i | input | 1 | Parallel phase generator step complete |
| ser_done_i | input | 1 | Serial phase generator step complete |
| img_shift_o | output | 1 | Step request to the image array parallel clocks |
| stor_shift_o | output | 1 | Step request to the storage array parallel clocks |
| ser_shift_o | output | 1 | Step request to the serial register clocks |
| pixel_valid_o | output | 1 | One pixel has left the output |
| pix_row_o | output | IDX_W | Row index of the pixel |
| pix_col_o | output | IDX_W | Column index of the pixel |
| frame_done_o | output | 1 | End-of-frame pulse |
| readout_o | output | 1 | 1 while a frame is being transferred or read |
| shutter_en_o | output | 1 | Shutter or strobe enable, 1 = exposing |

## Verification
Requests appear in the cycle after the state that issues them is entered. The bench model of the generators answers them one to three cycles later, and never in the request cycle itself. A pixel strobe is due exactly one cycle after the cycle that carried `ser_done_i`, and the frame-done pulse is due one cycle after that final strobe. The bench therefore samples every output on the falling edge. It compares the pixel strobe against the serial done it drove in the previous half period, and it checks order, counts and indices event by event against counters that it keeps from the requirements.

// File: rtl/area_readout_seq.sv
module area_readout_seq #(
  parameter int MAX_DIM = 4096,
  localparam int CNT_W = $clog2(MAX_DIM + 1),
  localparam int IDX_W = $clog2(MAX_DIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ft_mode_i,
  input  logic [CNT_W-1:0] rows_i,
  input  logic [CNT_W-1:0] cols_i,
  input  logic             par_done_i,
  input  logic             ser_done_i,
  output logic             img_shift_o,
  output logic             stor_shift_o,
  output logic             ser_shift_o,
  output logic             pixel_valid_o,
  output logic [IDX_W-1:0] pix_row_o,
  output logic [IDX_W-1:0] pix_col_o,
  output logic             frame_done_o,
  output logic             readout_o,
  output logic             shutter_en_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_DUMP_REQ, S_DUMP_WAIT, S_ROW_REQ, S_ROW_WAIT, S_SER_REQ, S_SER_WAIT, S_FINISH
  } st_t;

  st_t              st;
  logic             ft_q;
  logic [CNT_W-1:0] rows_q, cols_q;
  logic [CNT_W-1:0] row_c, col_c;

  wire last_row = (row_c == rows_q - CNT_W'(1));
  wire last_col = (col_c == cols_q - CNT_W'(1));
  wire go       = start_i && (rows_i != '0) && (cols_i != '0);

  assign img_shift_o  = (st == S_DUMP_REQ) || (st == S_ROW_REQ && !ft_q);
  assign stor_shift_o = (st == S_DUMP_REQ) || (st == S_ROW_REQ && ft_q);
  assign ser_shift_o  = (st == S_SER_REQ);
  assign readout_o    = (st != S_IDLE);
  assign shutter_en_o = ft_q || (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      ft_q          <= 1'b0;
      rows_q        <= '0;
      cols_q        <= '0;
      row_c         <= '0;
      col_c         <= '0;
      pixel_valid_o <= 1'b0;
      frame_done_o  <= 1'b0;
      pix_row_o     <= '0;
      pix_col_o     <= '0;
    end else begin
      pixel_valid_o <= 1'b0;
      frame_done_o  <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          ft_q   <= ft_mode_i;
          rows_q <= rows_i;
          cols_q <= cols_i;
          row_c  <= '0;
          col_c  <= '0;
          st     <= ft_mode_i ? S_DUMP_REQ : S_ROW_REQ;
        end
        S_DUMP_REQ: st <= S_DUMP_WAIT;
        S_DUMP_WAIT: if (par_done_i) begin
          if (last_row) begin
            row_c <= '0;
            st    <= S_ROW_REQ;
          end else begin
            row_c <= row_c + CNT_W'(1);
            st    <= S_DUMP_REQ;
          end
        end
        S_ROW_REQ: st <= S_ROW_WAIT;
        S_ROW_WAIT: if (par_done_i) begin
          col_c <= '0;
          st    <= S_SER_REQ;
        end
        S_SER_REQ: st <= S_SER_WAIT;
        S_SER_WAIT: if (ser_done_i) begin
          pixel_valid_o <= 1'b1;
          pix_row_o     <= row_c[IDX_W-1:0];
          pix_col_o     <= col_c[IDX_W-1:0];
          if (!last_col) begin
            col_c <= col_c + CNT_W'(1);
            st    <= S_SER_REQ;
          end else if (!last_row) begin
            row_c <= row_c + CNT_W'(1);
            st    <= S_ROW_REQ;
          end else begin
            st    <= S_FINISH;
          end
        end
        S_FINISH: begin
          frame_done_o <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/area_readout_seq_chk.sv
module area_readout_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_done_i,
  input logic img_shift_o,
  input logic stor_shift_o,
  input logic ser_shift_o,
  input logic pixel_valid_o,
  input logic frame_done_o,
  input logic readout_o,
  input logic shutter_en_o
);
  wire any_req = img_shift_o || stor_shift_o || ser_shift_o;

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> readout_o);
  p_no_mix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_shift_o |-> !(img_shift_o || stor_shift_o));
  p_valid_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid_o |-> $past(ser_done_i));
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!readout_o && $past(pixel_valid_o)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  p_ff_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (img_shift_o && !stor_shift_o) |-> !shutter_en_o);
  p_ft_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stor_shift_o |-> shutter_en_o);
endmodule

bind area_readout_seq area_readout_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_done_i(ser_done_i),
  .img_shift_o(img_shift_o), .stor_shift_o(stor_shift_o), .ser_shift_o(ser_shift_o),
  .pixel_valid_o(pixel_valid_o), .frame_done_o(frame_done_o),
  .readout_o(readout_o), .shutter_en_o(shutter_en_o)
);

// File: tb/tb_area_readout_seq.sv
`timescale 1ns/1ps
module tb_area_readout_seq;
  localparam int MAX_DIM = 4096;
  localparam int CNT_W = $clog2(MAX_DIM + 1);
  localparam int IDX_W = $clog2(MAX_DIM);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, ft_mode_i = 1'b0, par_done_i = 1'b0, ser_done_i = 1'b0;
  logic [CNT_W-1:0] rows_i = '0, cols_i = '0;
  logic img_shift_o, stor_shift_o, ser_shift_o, pixel_valid_o, frame_done_o, readout_o, shutter_en_o;
  logic [IDX_W-1:0] pix_row_o, pix_col_o;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  area_readout_seq #(.MAX_DIM(MAX_DIM)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ft_mode_i(ft_mode_i),
    .rows_i(rows_i), .cols_i(cols_i), .par_done_i(par_done_i), .ser_done_i(ser_done_i),
    .img_shift_o(img_shift_o), .stor_shift_o(stor_shift_o), .ser_shift_o(ser_shift_o),
    .pixel_valid_o(pixel_valid_o), .pix_row_o(pix_row_o), .pix_col_o(pix_col_o),
    .frame_done_o(frame_done_o), .readout_o(readout_o), .shutter_en_o(shutter_en_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 199000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_shutter(input bit ft, input bit busy);
    return ft || !busy;
  endfunction

  function automatic bit exp_readout_kind_ok(input bit ft, input bit img, input bit stor);
    return ft ? (stor && !img) : (img && !stor);
  endfunction

  task automatic idle_quiet(input int n, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (readout_o || img_shift_o || stor_shift_o || ser_shift_o || pixel_valid_o || frame_done_o) ok = 1'b0;
    end
    check(ok, req, "block stays idle", readout_o, 0);
  endtask

  task automatic run_frame(input bit ft, input int r, input int c, input bit disturb);
    int dumps = 0, pars = 0, cur_ser = 0, vr = 0, vc = 0, nvalid = 0, n = 0, pw = 0, sw = 0;
    bit got_done = 1'b0, shut_ok = 1'b1, pv_ok = 1'b1, ser_prev;
    @(negedge clk);
    ft_mode_i = ft; rows_i = CNT_W'(r); cols_i = CNT_W'(c); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(readout_o == 1'b1, "R2", "frame begins after start", readout_o, 1);
    while (!got_done) begin
      ser_prev = ser_done_i;
      par_done_i = 1'b0; ser_done_i = 1'b0;
      if (pw > 0) begin pw--; if (pw == 0) par_done_i = 1'b1; end
      if (sw > 0) begin sw--; if (sw == 0) ser_done_i = 1'b1; end
      n++;
      if (readout_o && shutter_en_o != exp_shutter(ft, 1'b1)) shut_ok = 1'b0;
      if (pixel_valid_o != ser_prev) pv_ok = 1'b0;
      if (disturb && n == 5) begin
        start_i = 1'b1; ft_mode_i = !ft; rows_i = CNT_W'(1); cols_i = CNT_W'(1);
      end
      if (disturb && n == 6) start_i = 1'b0;
      if (img_shift_o || stor_shift_o) begin
        if (ft && dumps < r) begin
          check(img_shift_o && stor_shift_o && !ser_shift_o, "R8", "dump drives both arrays", {img_shift_o, stor_shift_o}, 3);
          dumps++;
        end else begin
          check(exp_readout_kind_ok(ft, img_shift_o, stor_shift_o), ft ? "R8" : "R7",
                "readout parallel line", {img_shift_o, stor_shift_o}, ft ? 1 : 2);
          check(pars == 0 ? cur_ser == 0 : cur_ser == c, "R4", "serial steps in previous row", cur_ser, pars == 0 ? 0 : c);
          pars++;
          cur_ser = 0;
        end
        check(pw == 0 && sw == 0, "R3", "no request while one is outstanding", pw + sw, 0);
        pw = 1 + $urandom_range(0, 2);
      end
      if (ser_shift_o) begin
        check(pars > 0 && cur_ser < c && (!ft || dumps == r), "R4", "serial step order", cur_ser, c - 1);
        check(pw == 0 && sw == 0, "R3", "no request while one is outstanding", pw + sw, 0);
        cur_ser++;
        sw = 1 + $urandom_range(0, 2);
      end
      if (pixel_valid_o) begin
        check(int'(pix_row_o) == vr && int'(pix_col_o) == vc, "R5", "pixel row*65536+col",
              int'(pix_row_o) * 65536 + int'(pix_col_o), vr * 65536 + vc);
        vc++;
        if (vc == c) begin vc = 0; vr++; end
        nvalid++;
      end
      if (frame_done_o) begin
        check(nvalid == r * c, "R6", "pixel strobes per frame", nvalid, r * c);
        check(!readout_o, "R6", "readout low at frame done", readout_o, 0);
        got_done = 1'b1;
      end
      if (!got_done) @(negedge clk);
    end
    start_i = 1'b0; ft_mode_i = ft; par_done_i = 1'b0; ser_done_i = 1'b0;
    check(shut_ok, ft ? "R8" : "R7", "shutter level during readout", !shut_ok, 0);
    check(pv_ok, "R5", "pixel strobe one cycle after serial done", !pv_ok, 0);
    check(pars == r && dumps == (ft ? r : 0), "R4", "parallel readout steps", pars, r);
    check(shutter_en_o == 1'b1, ft ? "R8" : "R7", "shutter open when idle", shutter_en_o, 1);
    @(negedge clk);
    check(!frame_done_o, "R6", "frame done is one cycle", frame_done_o, 0);
    if (disturb) idle_quiet(6, "R9");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!readout_o && shutter_en_o && !img_shift_o && !stor_shift_o && !ser_shift_o
          && !pixel_valid_o && !frame_done_o, "R1", "reset state", readout_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!readout_o && shutter_en_o, "R1", "idle after reset", readout_o, 0);

    rows_i = '0; cols_i = CNT_W'(3); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idle_quiet(3, "R2");
    rows_i = CNT_W'(3); cols_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idle_quiet(3, "R2");

    run_frame(1'b0, 1, 1, 1'b0);
    run_frame(1'b1, 1, 1, 1'b0);
    run_frame(1'b0, 3, 4, 1'b1);
    run_frame(1'b1, 4, 3, 1'b1);
    for (int k = 0; k < 10; k++) begin
      int r = $urandom_range(1, 6);
      int c = $urandom_range(1, 6);
      run_frame(1'($urandom_range(0, 1)), r, c, (k % 2 == 1) && (r * c >= 4));
    end
    run_frame(1'b1, MAX_DIM, 1, 1'b0);
    run_frame(1'b0, 2, MAX_DIM, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule